// File: doc/BRIEF.md
# Instrument Bus Listener Acceptor

This block is the receiving end of the three-wire byte handshake used on a byte-serial, bit-parallel instrument bus. Every byte on the bus must be taken by all active acceptors before the talker may present the next one. The block watches the data-valid strobe, drives the not-ready-for-data and not-data-accepted lines, and decodes listen-address commands that the controller sends while the attention line is asserted. It also stores each data byte it accepts in a local data-in register, together with its end-of-string marker, for a local processor.

The local side sets the pace of the transfer. After a data byte is taken, the block holds the bus not-ready until the processor reads the byte. In the optional hold-off mode, it also stays not-ready after that read, until the processor issues an explicit release. A software-reset flag keeps the block off the bus. Reset sets this flag, and the processor must clear it before the block can take part in any transfer. All bus lines are active low, and bus data is positive logic on `bus_dio`.

Top module: `gpib_acceptor`

## Requirements
- R1: Reset sets the software-reset flag. It stays set until a `swrst_clr` pulse and is set again by a `swrst_set` pulse. While it is set, `nrfd_n` and `ndac_n` are both high, and `listening` is 0 and no command can set it.
- R2: A command byte is a byte received while `bus_atn_n` is low, and bit 7 of a command byte is ignored. Command bits [6:5] = 2'b01 with bits [4:0] equal to `dev_addr` set `listening`, provided `listen_dis` is low. The command value 7'h3F clears `listening`. While `listen_dis` is high, `listening` is held at 0.
- R3: While the software-reset flag is clear and either `bus_atn_n` is low or `listening` is 1, the block waits for a byte with `ndac_n` low. In that state `nrfd_n` is high only when the block can accept a byte. When the block is not listening and `bus_atn_n` is high, both lines are high.
- R4: Accepting a byte drives `ndac_n` high and `nrfd_n` low on the same clock edge. When the data-valid strobe returns high, `ndac_n` goes low before `nrfd_n` is released again.
- R5: A byte received while `bus_atn_n` is high and `listening` is 1 is stored in `din_data`. `din_end` is set to 1 if `bus_eoi_n` was low with that byte, and `byte_in` is set to 1.
- R6: After a data byte has been stored, `nrfd_n` stays low until a `din_rd` pulse. A stored byte is never overwritten by a later one.
- R7: A `din_rd` pulse or a `stat_rd` pulse clears `byte_in`. A `stat_rd` pulse does not free the data-in register, so `nrfd_n` stays low.
- R8: When `hold_en` is high as a data byte is accepted, `nrfd_n` stays low even after `din_rd`, until a `hold_release` pulse.
- R9: Command bytes complete their handshake without any local read. They leave `din_data` and `byte_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_dio | input | 8 | Bus data, positive logic |
| bus_dav_n | input | 1 | Data-valid strobe, active low, asynchronous |
| bus_eoi_n | input | 1 | End-of-string line, active low |
| bus_atn_n | input | 1 | Attention (command mode), active low, asynchronous |
| nrfd_n | output | 1 | Not ready for data, active low |
| ndac_n | output | 1 | Not data accepted, active low |
| dev_addr | input | 5 | Local device address |
| listen_dis | input | 1 | Disables the listener function when high |
| swrst_set | input | 1 | Pulse that sets the software-reset flag |
| swrst_clr | input | 1 | Pulse that clears the software-reset flag |
| hold_en | input | 1 | Enables the hold-off mode after each data byte |
| hold_release | input | 1 | Pulse that ends an active hold-off |
| din_rd | input | 1 | Pulse marking a read of the data-in register |
| stat_rd | input | 1 | Pulse marking a read of the status register |
| din_data | output | 8 | Last data byte accepted |
| din_end | output | 1 | End-of-string flag of the last data byte |
| byte_in | output | 1 | Byte-in status flag |
| listening | output | 1 | Addressed as a listener |

## Verification
The bench goes after the case where a stored byte is never read. A design that freed the bus when the byte was captured, or when only the status was read, would release `nrfd_n` early and let the talker overwrite unread data. It checks that a hold-off survives the data read: a block that dropped the hold-off on `din_rd` would restart the transfer before the processor allows it. A monitor follows the order of the two handshake lines on every cycle, to catch a design that releases NRFD before re-asserting NDAC. Unaddressing, disabled listening and software reset are each checked for a block that keeps blocking the bus or answers bytes meant for others.

// File: rtl/gpib_acc_pkg.sv
package gpib_acc_pkg;
  localparam int ADDR_W   = 5;
  localparam int BYTE_W   = 8;
  localparam logic [1:0] LISTEN_GRP = 2'b01;
  localparam logic [6:0] UNLISTEN   = 7'h3F;

  typedef enum logic [1:0] {
    HS_OFF   = 2'd0,
    HS_HOLD  = 2'd1,
    HS_READY = 2'd2,
    HS_TAKEN = 2'd3
  } hs_state_t;
endpackage

// File: rtl/gpib_sync.sv
module gpib_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpib_hs_fsm.sv
module gpib_hs_fsm
  import gpib_acc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic participate,
  input  logic ready_ok,
  input  logic dav_n_s,
  output logic take,
  output logic nrfd_n,
  output logic ndac_n
);
  hs_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    if (!participate) begin
      state_d = HS_OFF;
    end else begin
      case (state_q)
        HS_OFF:   state_d = HS_HOLD;
        HS_HOLD:  if (ready_ok && dav_n_s) state_d = HS_READY;
        HS_READY: begin
          if (!ready_ok) begin
            state_d = HS_HOLD;
          end else if (!dav_n_s) begin
            state_d = HS_TAKEN;
            take    = 1'b1;
          end
        end
        HS_TAKEN: if (dav_n_s) state_d = HS_HOLD;
        default:  state_d = HS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_OFF;
      nrfd_n  <= 1'b1;
      ndac_n  <= 1'b1;
    end else begin
      state_q <= state_d;
      nrfd_n  <= (state_d == HS_OFF) || (state_d == HS_READY);
      ndac_n  <= (state_d == HS_OFF) || (state_d == HS_TAKEN);
    end
  end

  AST_NDAC_BEFORE_NRFD: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_TAKEN) |=> (state_q != HS_READY)); // R4

  AST_TAKE_RELEASES_NDAC: assert property (@(posedge clk) disable iff (rst)
    take |=> (ndac_n && !nrfd_n)); // R4
endmodule

// File: rtl/gpib_din_reg.sv
module gpib_din_reg
  import gpib_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic              bus_end,
  input  logic              din_rd,
  input  logic              stat_rd,
  input  logic              hold_en,
  input  logic              hold_release,
  output logic [BYTE_W-1:0] data_q,
  output logic              end_q,
  output logic              full_q,
  output logic              byte_in_q,
  output logic              hold_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      end_q     <= 1'b0;
      full_q    <= 1'b0;
      byte_in_q <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      if (din_rd)               full_q    <= 1'b0;
      if (din_rd || stat_rd)    byte_in_q <= 1'b0;
      if (hold_release)         hold_q    <= 1'b0;
      if (latch) begin
        data_q    <= bus_data;
        end_q     <= bus_end;
        full_q    <= 1'b1;
        byte_in_q <= 1'b1;
        if (hold_en) hold_q <= 1'b1;
      end
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    latch |-> !full_q); // R6

  AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((din_rd || stat_rd) && !latch) |=> !byte_in_q); // R7
endmodule

// File: rtl/gpib_acceptor.sv
module gpib_acceptor
  import gpib_acc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] bus_dio,
  input  logic              bus_dav_n,
  input  logic              bus_eoi_n,
  input  logic              bus_atn_n,
  output logic              nrfd_n,
  output logic              ndac_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              listen_dis,
  input  logic              swrst_set,
  input  logic              swrst_clr,
  input  logic              hold_en,
  input  logic              hold_release,
  input  logic              din_rd,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] din_data,
  output logic              din_end,
  output logic              byte_in,
  output logic              listening
);
  logic [1:0] ctl_s;
  logic       dav_n_s, atn_s;
  logic       swrst_q, lads_q;
  logic       participate, ready_ok, take, latch_data;
  logic       full_q, hold_q;
  logic [6:0] cmd;

  gpib_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_dav_n, bus_atn_n}),
    .q   (ctl_s)
  );
  assign dav_n_s = ctl_s[1];
  assign atn_s   = !ctl_s[0];
  assign cmd     = bus_dio[6:0];

  always_ff @(posedge clk) begin
    if (rst || swrst_set)  swrst_q <= 1'b1;
    else if (swrst_clr)    swrst_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || swrst_q || swrst_set || listen_dis) begin
      lads_q <= 1'b0;
    end else if (take && atn_s) begin
      if (cmd == UNLISTEN)                        lads_q <= 1'b0;
      else if (cmd == {LISTEN_GRP, dev_addr})     lads_q <= 1'b1;
    end
  end

  assign participate = !swrst_q && (atn_s || lads_q);
  assign ready_ok    = atn_s || (!full_q && !hold_q);
  assign latch_data  = take && !atn_s;

  gpib_hs_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .participate (participate),
    .ready_ok    (ready_ok),
    .dav_n_s     (dav_n_s),
    .take        (take),
    .nrfd_n      (nrfd_n),
    .ndac_n      (ndac_n)
  );

  gpib_din_reg u_din (
    .clk          (clk),
    .rst          (rst),
    .latch        (latch_data),
    .bus_data     (bus_dio),
    .bus_end      (!bus_eoi_n),
    .din_rd       (din_rd),
    .stat_rd      (stat_rd),
    .hold_en      (hold_en),
    .hold_release (hold_release),
    .data_q       (din_data),
    .end_q        (din_end),
    .full_q       (full_q),
    .byte_in_q    (byte_in),
    .hold_q       (hold_q)
  );

  assign listening = lads_q;

  AST_BYTEIN_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_in) |-> $past(lads_q)); // R5

  AST_SWRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (swrst_q && $past(swrst_q)) |-> (nrfd_n && ndac_n && !lads_q)); // R1

  AST_DATA_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    (latch_data && hold_en) |=> !nrfd_n); // R8
endmodule

// File: tb/tb_gpib_acceptor.sv
module tb_gpib_acceptor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_dio = 8'h00;
  logic       bus_dav_n = 1'b1, bus_eoi_n = 1'b1, bus_atn_n = 1'b1;
  logic       nrfd_n, ndac_n;
  logic [4:0] dev_addr = 5'd9;
  logic       listen_dis = 1'b0, swrst_set = 1'b0, swrst_clr = 1'b0;
  logic       hold_en = 1'b0, hold_release = 1'b0, din_rd = 1'b0, stat_rd = 1'b0;
  logic [7:0] din_data;
  logic       din_end, byte_in, listening;

  int checks = 0, errors = 0, viol = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic prev_nrfd = 1'b1, prev_ndac = 1'b1;

  always #4 clk = ~clk;

  gpib_acceptor dut (
    .clk(clk), .rst(rst), .bus_dio(bus_dio), .bus_dav_n(bus_dav_n),
    .bus_eoi_n(bus_eoi_n), .bus_atn_n(bus_atn_n), .nrfd_n(nrfd_n),
    .ndac_n(ndac_n), .dev_addr(dev_addr), .listen_dis(listen_dis),
    .swrst_set(swrst_set), .swrst_clr(swrst_clr), .hold_en(hold_en),
    .hold_release(hold_release), .din_rd(din_rd), .stat_rd(stat_rd),
    .din_data(din_data), .din_end(din_end), .byte_in(byte_in),
    .listening(listening)
  );

  // R4 order monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (nrfd_n && !prev_nrfd && ndac_n) viol++;
      if (ndac_n && !prev_ndac && nrfd_n) viol++;
      if (nrfd_n && ndac_n) viol++;
    end
    prev_nrfd <= nrfd_n;
    prev_ndac <= ndac_n;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_nrfd(input logic v, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 60 && !ok; i++) begin
      if (nrfd_n === v) ok = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic wait_ndac(input logic v, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 60 && !ok; i++) begin
      if (ndac_n === v) ok = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit e, output bit ok,
                      output logic nrfd_at_take);
    bit a, c, d;
    wait_nrfd(1'b1, a);
    bus_dio = b;
    bus_eoi_n = !e;
    @(negedge clk);
    bus_dav_n = 1'b0;
    wait_ndac(1'b1, c);
    nrfd_at_take = nrfd_n;
    bus_dav_n = 1'b1;
    bus_eoi_n = 1'b1;
    wait_ndac(1'b0, d);
    ok = a && c && d;
  endtask

  task automatic pulse_rd();
    din_rd = 1'b1; @(negedge clk); din_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk(nrfd_n === 1'b1, "R1", "nrfd after reset", nrfd_n, 1);
    chk(ndac_n === 1'b1, "R1", "ndac after reset", ndac_n, 1);
    chk(byte_in === 1'b0, "R5", "byte_in after reset", byte_in, 0);
    chk(listening === 1'b0, "R1", "listening after reset", listening, 0);
  endtask

  task automatic t_swrst_blocks();
    bit ok; logic n;
    bus_atn_n = 1'b0; tick(6);
    chk(ndac_n === 1'b1, "R1", "ndac held off in swrst", ndac_n, 1);
    send(8'h29, 1'b0, ok, n);
    tick(4);
    chk(listening === 1'b0, "R1", "address ignored in swrst", listening, 0);
    bus_atn_n = 1'b1; tick(4);
    swrst_clr = 1'b1; @(negedge clk); swrst_clr = 1'b0; tick(3);
  endtask

  task automatic t_address();
    bit ok; logic n;
    bus_atn_n = 1'b0; tick(6);
    chk(ndac_n === 1'b0, "R3", "ndac asserted in command mode", ndac_n, 0);
    chk(nrfd_n === 1'b1, "R3", "ready in command mode", nrfd_n, 1);
    send(8'hA9, 1'b0, ok, n);   // bit 7 set, still MLA 9
    chk(ok, "R9", "command handshake completes", ok, 1);
    chk(listening === 1'b1, "R2", "listen address accepted", listening, 1);
    chk(byte_in === 1'b0, "R9", "command not captured", byte_in, 0);
    mon_en = 1'b1;
    bus_atn_n = 1'b1; tick(6);
    chk(ndac_n === 1'b0 && nrfd_n === 1'b1, "R3", "addressed idle lines",
        {ndac_n, nrfd_n}, 2'b01);
  endtask

  task automatic t_data();
    bit ok; logic n;
    send(8'hA5, 1'b0, ok, n);
    chk(ok && n === 1'b0, "R4", "nrfd low when ndac released", n, 0);
    tick(2);
    chk(byte_in === 1'b1, "R5", "byte_in set", byte_in, 1);
    chk(din_data === 8'hA5, "R5", "data captured", din_data, 8'hA5);
    chk(din_end === 1'b0, "R5", "no end flag", din_end, 0);
    chk(ndac_n === 1'b0 && nrfd_n === 1'b0, "R4", "both asserted after DAV high",
        {ndac_n, nrfd_n}, 0);
    tick(20);
    chk(nrfd_n === 1'b0, "R6", "nrfd held while unread", nrfd_n, 0);
    pulse_rd();
    wait_nrfd(1'b1, ok);
    chk(ok, "R6", "nrfd released after read", nrfd_n, 1);
    chk(byte_in === 1'b0, "R7", "din_rd clears byte_in", byte_in, 0);
  endtask

  task automatic t_eoi_stat();
    bit ok; logic n;
    send(8'h3C, 1'b1, ok, n);
    tick(2);
    chk(din_end === 1'b1 && din_data === 8'h3C, "R5", "end flag captured",
        {din_end, din_data}, 9'h13C);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; tick(2);
    chk(byte_in === 1'b0, "R7", "stat_rd clears byte_in", byte_in, 0);
    tick(10);
    chk(nrfd_n === 1'b0, "R7", "stat_rd keeps register full", nrfd_n, 0);
    pulse_rd();
    wait_nrfd(1'b1, ok);
    chk(ok, "R6", "released after data read", nrfd_n, 1);
  endtask

  task automatic t_hold();
    bit ok; logic n;
    hold_en = 1'b1;
    send(8'h5A, 1'b0, ok, n);
    tick(2);
    pulse_rd();
    tick(15);
    chk(nrfd_n === 1'b0, "R8", "hold-off survives data read", nrfd_n, 0);
    hold_en = 1'b0;
    hold_release = 1'b1; @(negedge clk); hold_release = 1'b0;
    wait_nrfd(1'b1, ok);
    chk(ok, "R8", "release frees handshake", nrfd_n, 1);
  endtask

  task automatic t_unlisten();
    bit ok; logic n;
    bus_atn_n = 1'b0; tick(6);
    send(8'h3F, 1'b0, ok, n);
    chk(listening === 1'b0, "R2", "unlisten clears", listening, 0);
    chk(din_data === 8'h5A, "R9", "command leaves data", din_data, 8'h5A);
    mon_en = 1'b0;
    bus_atn_n = 1'b1; tick(6);
    chk(nrfd_n === 1'b1 && ndac_n === 1'b1, "R3", "unaddressed releases lines",
        {nrfd_n, ndac_n}, 2'b11);
  endtask

  task automatic t_disable();
    bit ok; logic n;
    bus_atn_n = 1'b0; tick(6);
    listen_dis = 1'b1;
    send(8'h29, 1'b0, ok, n);
    tick(2);
    chk(listening === 1'b0, "R2", "listen_dis blocks address", listening, 0);
    listen_dis = 1'b0;
    send(8'h2B, 1'b0, ok, n);
    tick(2);
    chk(listening === 1'b0, "R2", "other address ignored", listening, 0);
    send(8'h29, 1'b0, ok, n);
    tick(2);
    chk(listening === 1'b1, "R2", "address after enable", listening, 1);
    bus_atn_n = 1'b1; tick(6);
  endtask

  task automatic t_swrst_mid();
    swrst_set = 1'b1; @(negedge clk); swrst_set = 1'b0; tick(4);
    chk(nrfd_n === 1'b1 && ndac_n === 1'b1, "R1", "swrst releases lines",
        {nrfd_n, ndac_n}, 2'b11);
    chk(listening === 1'b0, "R1", "swrst unaddresses", listening, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_swrst_blocks();
    t_address();
    t_data();
    t_eoi_stat();
    t_hold();
    t_unlisten();
    t_disable();
    t_swrst_mid();
    chk(viol == 0, "R4", "handshake order monitor", viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule